// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter with Consistency Flag

This block is a free-running cycle counter, 64 bits wide by default, that software reads as two 32-bit words over a simple register bus. A 64-bit value read as two halves can tear. The low word may wrap between the two reads, which carries into the high word. An interrupt can also land between the reads and delay the second one for an unbounded time. To let software detect this, a small window tracker follows the read sequence "low word, then high word, then control". It reports in a status bit of the control word whether the pair just read belongs together. Software repeats the three reads until that bit comes back as 1.

The counter runs only while the enable bit of the control register is set. There is no way to write the count. Only a synchronous reset brings it back to zero. An event input, pulsed by the core on interrupt or exception entry, spoils any pair whose reads it falls between. Each counter half is `HALF_W` bits wide, zero-extended onto the 32-bit bus. A small `HALF_W` gives a fast-wrapping counter for testing.

Top module: `sctr_split_counter`

## Requirements
- R1: A synchronous active-high reset clears the count to zero, disables counting, closes the read window and sets the read data output to zero.
- R2: A write to address 0x103 loads the enable bit from write-data bit 0. Other write-data bits are ignored. While enabled, the count rises by exactly one at every clock edge, starting at the edge after the write. While disabled, the count holds.
- R3: A read of address 0x104 returns the low `HALF_W` bits of the count, zero-extended. The value is the count in the read cycle, and it appears on the read data output after the next clock edge.
- R4: A read of address 0x105 returns the upper `HALF_W` bits of the count in the same way. The read data output changes only after a read.
- R5: A read of address 0x103 returns the enable in bit 0 and the consistency status in bit 31. All other bits read as zero.
- R6: The status bit is 1 only when three conditions hold. The control read follows a low read and then a high read. No event was seen from the low-read cycle through the high-read cycle. The low half did not wrap between the low-read cycle and the cycle before the high read.
- R7: An event input pulse, or a wrap of the low half, inside that window makes the following control read report status 0.
- R8: A high read with no open window, a second high read, or a control read without a preceding low-then-high pair gives status 0.
- R9: A control read closes the window, so an immediately repeated control read reports status 0.
- R10: A new low read restarts the window and discards any earlier violation.
- R11: Reads of any other address return zero. Writes to any address other than 0x103 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data |
| irq_evt | input | 1 | Pulse on interrupt or exception entry |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
The hardest case to reach from the ports is a low-half wrap that falls exactly inside the window between the low and high reads. With a 32-bit half, that takes billions of cycles. The bench therefore builds the counter with 8-bit halves, so that a wrap comes every 256 enabled cycles. It then runs over a thousand read sequences of varying gap lengths and event placement, which slides the low-read point across every value of the low half, including the last one before a wrap. An arithmetic model of the count and the window predicts every read word. The bench also confirms that both wrap-spoiled and consistent pairs actually occurred.

// File: rtl/sctr_pkg.sv
package sctr_pkg;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 12;
    localparam int STAT_BIT = 31;
    localparam int EN_BIT   = 0;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 12'h103;
    localparam logic [ADDR_W-1:0] ADDR_LO   = 12'h104;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 12'h105;

    typedef enum logic [1:0] {
        WIN_IDLE    = 2'd0,
        WIN_LO_SEEN = 2'd1,
        WIN_HI_SEEN = 2'd2
    } win_phase_e;

    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic rd_ctrl;
        logic rd_other;
        logic wr_ctrl;
    } bus_dec_t;

    function automatic bus_dec_t decode_access(
        input logic              rd,
        input logic              wr,
        input logic [ADDR_W-1:0] addr
    );
        bus_dec_t d;
        d.rd_lo    = rd && (addr == ADDR_LO);
        d.rd_hi    = rd && (addr == ADDR_HI);
        d.rd_ctrl  = rd && (addr == ADDR_CTRL);
        d.rd_other = rd && !(d.rd_lo || d.rd_hi || d.rd_ctrl);
        d.wr_ctrl  = wr && (addr == ADDR_CTRL);
        return d;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctrl(input logic en, input logic ok);
        logic [BUS_W-1:0] w;
        w           = '0;
        w[STAT_BIT] = ok;
        w[EN_BIT]   = en;
        return w;
    endfunction

endpackage

// File: rtl/sctr_count_core.sv
module sctr_count_core #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o,
    output logic              wrap_o
);
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    logic              lo_full;

    assign lo_full = &lo_q;
    assign wrap_o  = run_i && lo_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (run_i) begin
            lo_q <= lo_q + 1'b1;
            if (lo_full) begin
                hi_q <= hi_q + 1'b1;
            end
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;
endmodule

// File: rtl/sctr_read_tracker.sv
module sctr_read_tracker
    import sctr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_dec_t   dec_i,
    input  logic       evt_i,
    input  logic       wrap_i,
    output win_phase_e phase_o,
    output logic       report_o
);
    win_phase_e phase_q;
    logic       ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= WIN_IDLE;
            ok_q    <= 1'b0;
        end else if (dec_i.rd_ctrl) begin
            phase_q <= WIN_IDLE;
            ok_q    <= 1'b0;
        end else if (dec_i.rd_lo) begin
            phase_q <= WIN_LO_SEEN;
            ok_q    <= !(evt_i || wrap_i);
        end else if (dec_i.rd_hi) begin
            if (phase_q == WIN_LO_SEEN) begin
                phase_q <= WIN_HI_SEEN;
                ok_q    <= ok_q && !evt_i;
            end else begin
                phase_q <= WIN_IDLE;
                ok_q    <= 1'b0;
            end
        end else if (phase_q == WIN_LO_SEEN) begin
            ok_q <= ok_q && !(evt_i || wrap_i);
        end
    end

    assign phase_o  = phase_q;
    assign report_o = ok_q && (phase_q == WIN_HI_SEEN);
endmodule

// File: rtl/sctr_reg_port.sv
module sctr_reg_port
    import sctr_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [HALF_W-1:0] lo_i,
    input  logic [HALF_W-1:0] hi_i,
    input  logic              report_i,
    output bus_dec_t          dec_o,
    output logic              run_o,
    output logic [BUS_W-1:0]  rdata_o
);
    localparam int PAD_W = BUS_W - HALF_W;

    logic [BUS_W-1:0] lo_ext;
    logic [BUS_W-1:0] hi_ext;
    logic [BUS_W-1:0] rd_mux;
    logic             run_q;
    logic [BUS_W-1:0] rdata_q;
    bus_dec_t         dec;

    generate
        if (PAD_W == 0) begin : g_full_width
            assign lo_ext = lo_i;
            assign hi_ext = hi_i;
        end else begin : g_zero_pad
            assign lo_ext = {{PAD_W{1'b0}}, lo_i};
            assign hi_ext = {{PAD_W{1'b0}}, hi_i};
        end
    endgenerate

    assign dec = decode_access(rd_i, wr_i, addr_i);

    always_comb begin
        rd_mux = '0;
        if (dec.rd_lo) begin
            rd_mux = lo_ext;
        end else if (dec.rd_hi) begin
            rd_mux = hi_ext;
        end else if (dec.rd_ctrl) begin
            rd_mux = pack_ctrl(run_q, report_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (dec.wr_ctrl) begin
                run_q <= wdata_i[EN_BIT];
            end
            if (rd_i) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign dec_o   = dec;
    assign run_o   = run_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/sctr_split_counter.sv
module sctr_split_counter
    import sctr_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              irq_evt,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic [HALF_W-1:0] cnt_lo_w;
    logic [HALF_W-1:0] cnt_hi_w;
    logic              wrap_w;
    logic              run_w;
    logic              report_w;
    win_phase_e        phase_w;
    bus_dec_t          dec_w;

    sctr_reg_port #(.HALF_W(HALF_W)) port_i (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (bus_rd),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .lo_i     (cnt_lo_w),
        .hi_i     (cnt_hi_w),
        .report_i (report_w),
        .dec_o    (dec_w),
        .run_o    (run_w),
        .rdata_o  (bus_rdata)
    );

    sctr_count_core #(.HALF_W(HALF_W)) core_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run_w),
        .lo_o   (cnt_lo_w),
        .hi_o   (cnt_hi_w),
        .wrap_o (wrap_w)
    );

    sctr_read_tracker track_i (
        .clk      (clk),
        .rst      (rst),
        .dec_i    (dec_w),
        .evt_i    (irq_evt),
        .wrap_i   (wrap_w),
        .phase_o  (phase_w),
        .report_o (report_w)
    );
endmodule

// File: rtl/sctr_split_counter_chk.sv
module sctr_split_counter_chk
    import sctr_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq_evt,
    input logic              run,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input win_phase_e        phase,
    input logic              report,
    input logic [BUS_W-1:0]  bus_rdata
);
    logic [2*HALF_W-1:0] full_cnt;
    logic                rd_ctrl;
    logic                rd_lo;

    assign full_cnt = {cnt_hi, cnt_lo};
    assign rd_ctrl  = bus_rd && (bus_addr == ADDR_CTRL);
    assign rd_lo    = bus_rd && (bus_addr == ADDR_LO);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        run |=> full_cnt == $past(full_cnt) + 1'b1);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(full_cnt));

    assert_ctrl_reserved_R5: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl |=> bus_rdata[30:1] == '0);

    assert_event_spoils_R7: assert property (@(posedge clk) disable iff (rst)
        ((phase == WIN_LO_SEEN) || rd_lo) && irq_evt && !rd_ctrl |=> !report);

    assert_bad_order_R8: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl && (phase != WIN_HI_SEEN) |=> !bus_rdata[STAT_BIT]);

    assert_window_closes_R9: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl |=> phase == WIN_IDLE);

    assert_window_opens_R10: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> phase == WIN_LO_SEEN);
endmodule

bind sctr_split_counter sctr_split_counter_chk #(.HALF_W(HALF_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .irq_evt   (irq_evt),
    .run       (run_w),
    .cnt_lo    (cnt_lo_w),
    .cnt_hi    (cnt_hi_w),
    .phase     (phase_w),
    .report    (report_w),
    .bus_rdata (bus_rdata)
);

// File: tb/sctr_split_counter_tb_top.sv
`timescale 1ns/1ps
module sctr_split_counter_tb_top;
    localparam int HW = 8;
    localparam logic [11:0] A_CTRL = 12'h103;
    localparam logic [11:0] A_LO   = 12'h104;
    localparam logic [11:0] A_HI   = 12'h105;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        irq_evt = 1'b0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [2*HW-1:0] m_cnt;
    bit              m_en;
    int              m_ph;
    bit              m_ok;
    logic [31:0]     m_rdata;

    always #10 clk = ~clk;

    sctr_split_counter #(.HALF_W(HW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .irq_evt   (irq_evt),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_en = 0; m_ph = 0; m_ok = 0; m_rdata = '0;
    endtask

    // One bus cycle, starting and ending at a falling edge.
    task automatic step(input bit rd, input bit wr, input logic [11:0] a,
                        input logic [31:0] wd, input bit ev);
        bit wrap;
        bit rc, rl, rh;
        wrap = m_en && (m_cnt[HW-1:0] == '1);
        rc = rd && (a == A_CTRL);
        rl = rd && (a == A_LO);
        rh = rd && (a == A_HI);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; irq_evt = ev;
        if (rd) begin
            if (rc)      m_rdata = {(m_ok && m_ph == 2), 30'b0, m_en};
            else if (rl) m_rdata = {{(32-HW){1'b0}}, m_cnt[HW-1:0]};
            else if (rh) m_rdata = {{(32-HW){1'b0}}, m_cnt[2*HW-1:HW]};
            else         m_rdata = '0;
        end
        if (rc) begin
            m_ph = 0; m_ok = 0;
        end else if (rl) begin
            m_ph = 1; m_ok = !(ev || wrap);
        end else if (rh) begin
            if (m_ph == 1) begin m_ph = 2; m_ok = m_ok && !ev; end
            else begin m_ph = 0; m_ok = 0; end
        end else if (m_ph == 1) begin
            m_ok = m_ok && !(ev || wrap);
        end
        if (m_en) m_cnt = m_cnt + 1'b1;
        if (wr && a == A_CTRL) m_en = wd[0];
        @(posedge clk);
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; irq_evt = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input bit ev, input string tag);
        step(1, 0, a, '0, ev);
        chk(tag, bus_rdata, m_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0);
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n_good;
        int n_wrap_bad;
        n_good = 0;
        n_wrap_bad = 0;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rd_chk(A_CTRL, 0, "R1 ctrl after reset");
        rd_chk(A_LO, 0, "R1 low after reset");
        idle(5);
        rd_chk(A_LO, 0, "R1 count held while disabled");

        // R2/R11: ignored bits and addresses
        step(0, 1, A_CTRL, 32'hFFFF_FFFE, 0);
        rd_chk(A_CTRL, 0, "R2 upper write bits ignored");
        step(0, 1, 12'h106, 32'h1, 0);
        step(0, 1, A_LO, 32'h1, 0);
        rd_chk(A_CTRL, 0, "R11 write elsewhere ignored");
        rd_chk(12'h200, 0, "R11 unmapped read");

        // R2/R3/R4: counting
        step(0, 1, A_CTRL, 32'h1, 0);
        for (int i = 0; i < 6; i++) rd_chk(A_LO, 0, "R3 low word counts");
        rd_chk(A_HI, 0, "R4 high word");
        idle(3);
        chk("R4 rdata holds without read", bus_rdata, m_rdata);
        rd_chk(A_CTRL, 0, "R5 ctrl shows enable");

        // R6/R7: sweep of sequences across all low-half values
        for (int t = 0; t < 1500; t++) begin
            int g1, g2, ep;
            bit st;
            g1 = t % 4;
            g2 = (t / 4) % 3;
            ep = (t / 12) % 5;
            rd_chk(A_LO, ep == 1, "R3 sweep low");
            for (int k = 0; k < g1; k++) step(0, 0, '0, '0, (ep == 2) && (k == 0));
            rd_chk(A_HI, ep == 3, "R4 sweep high");
            for (int k = 0; k < g2; k++) step(0, 0, '0, '0, (ep == 4) && (k == 0));
            rd_chk(A_CTRL, 0, "R6 R7 sweep status");
            st = bus_rdata[31];
            if (st) n_good++;
            else if (ep == 0 || ep == 4 || (ep == 2 && g1 == 0)) n_wrap_bad++;
        end
        chk("R6 consistent pairs occurred", (n_good > 0) ? 32'h1 : 32'h0, 32'h1);
        chk("R7 wrap-spoiled pairs occurred", (n_wrap_bad > 0) ? 32'h1 : 32'h0, 32'h1);

        // R8: order violations
        rd_chk(A_HI, 0, "R8 high without low");
        rd_chk(A_CTRL, 0, "R8 status after lone high");
        chk("R8 lone high status 0", {31'b0, bus_rdata[31]}, 32'h0);
        rd_chk(A_LO, 0, "R8 low");
        rd_chk(A_CTRL, 0, "R8 status skipping high");
        chk("R8 skip high status 0", {31'b0, bus_rdata[31]}, 32'h0);
        rd_chk(A_LO, 0, "R8 low");
        rd_chk(A_HI, 0, "R8 high");
        rd_chk(A_HI, 0, "R8 second high");
        rd_chk(A_CTRL, 0, "R8 status after double high");
        chk("R8 double high status 0", {31'b0, bus_rdata[31]}, 32'h0);

        // R9: window closes
        rd_chk(A_LO, 0, "R9 low");
        rd_chk(A_HI, 0, "R9 high");
        rd_chk(A_CTRL, 0, "R9 first ctrl");
        rd_chk(A_CTRL, 0, "R9 repeated ctrl");
        chk("R9 repeated ctrl status 0", {31'b0, bus_rdata[31]}, 32'h0);

        // R10: restart after a spoiled window
        rd_chk(A_LO, 0, "R10 low");
        step(0, 0, '0, '0, 1);
        rd_chk(A_LO, 0, "R10 restart low");
        rd_chk(A_HI, 0, "R10 high");
        rd_chk(A_CTRL, 0, "R10 status after restart");

        // R2: disable freezes; no wrap so pair is consistent
        step(0, 1, A_CTRL, 32'h0, 0);
        rd_chk(A_LO, 0, "R2 frozen low");
        idle(4);
        rd_chk(A_HI, 0, "R2 frozen high");
        rd_chk(A_CTRL, 0, "R6 status when frozen");
        chk("R6 frozen pair consistent", bus_rdata, 32'h8000_0000);
        rd_chk(A_LO, 0, "R2 low still frozen");

        // R1: reset in mid-run
        step(0, 1, A_CTRL, 32'h1, 0);
        idle(300);
        do_reset();
        chk("R1 rdata cleared", bus_rdata, 32'h0);
        rd_chk(A_HI, 0, "R1 high cleared");
        idle(3);
        rd_chk(A_LO, 0, "R1 counting disabled after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule